// File: doc/BRIEF.md
# Host Control Register Bank

This block is a byte-wide register bank that an 8-bit host processor reads and writes through a simple request/acknowledge handshake. It has a 5-bit address space. The lower sixteen addresses hold the bank's own registers: a main control register, a second control byte, a scratchpad, a status byte, a configuration/readback data port, a 16-bit readback address and a 32-bit device identifier. The device identifier is read-only, is fixed by a parameter and is laid out as four bytes. The upper sixteen addresses form a user window. Accesses to the user window are passed straight through to user logic.

The main control register drives three request lines to the rest of the device. The global set/reset request is active high and resets to 0. The readback request and the program request are active low and reset to 1. The bank is cleared only by its own reset input. None of these requests reaches back into it, so the host can raise global set/reset or program and still read and write every bank register.

An access runs through a three-state machine. ST_IDLE waits for `req_i`. The transition IDLE_TO_EXEC latches the address, direction and write data. ST_EXEC commits the write or captures the read data, and pulses any strobe, then always moves to ST_DONE (EXEC_TO_DONE). ST_DONE holds `ack_o` high while `req_i` stays high (DONE_HOLD). It returns to ST_IDLE once the host drops `req_i` (DONE_TO_IDLE).

Top module: `host_ctrl_bank`

## Requirements
- R1: After reset, address 0x00 reads 0xA0, `glob_reset_req_o` is 0, and `readback_req_n_o` and `program_req_n_o` are 1. Addresses 0x01, 0x02, 0x05 and 0x06 read 0x00, and `ack_o` and all strobes are 0.
- R2: If `req_i` rises while the bank is idle, `ack_o` rises two clock edges later. `ack_o` stays high while `req_i` stays high and falls on the first edge after `req_i` falls. `rdata_o` holds the read result while `ack_o` is high.
- R3: A write to 0x00 sets the three requests from the written byte: bit 0 drives `glob_reset_req_o` (active high), bit 5 drives `readback_req_n_o` (active low) and bit 7 drives `program_req_n_o` (active low). Each request holds its value until the next write to 0x00.
- R4: Bits 1–4 and 6 of address 0x00 always read 0, whatever was written to them.
- R5: Addresses 0x01 (control 2), 0x02 (scratchpad), 0x05 (readback address low byte) and 0x06 (readback address high byte) are read/write. `rb_addr_o` equals {0x06, 0x05}, and `ctrl2_o` equals 0x01.
- R6: Address 0x03 reads `status_i`, and writes to it have no effect.
- R7: A write to 0x04 pulses `cfg_wr_stb_o` for one cycle with the byte on `cfg_wdata_o`. A read of 0x04 pulses `cfg_rd_stb_o` for one cycle and returns `cfg_rdata_i`.
- R8: Addresses 0x07 to 0x0A return the bytes of the DEVICE_ID parameter, least significant byte at 0x07 and most significant at 0x0A. Writes to these addresses are ignored.
- R9: Addresses 0x0B to 0x0F read 0x00, and writes to them change no register.
- R10: Each access to 0x10–0x1F pulses `user_stb_o` for exactly one cycle. During that cycle `user_addr_o` carries the low 4 address bits, `user_we_o` the direction and `user_wdata_o` the write data. A read of the window returns `user_rdata_i`.
- R11: While `glob_reset_req_o` is 1 or `program_req_n_o` is 0, every register at 0x00–0x0F keeps its value and stays readable and writable.
- R12: Each access pulses at most one of `user_stb_o`, `cfg_wr_stb_o` and `cfg_rd_stb_o`. The three request outputs, `ctrl2_o` and `rb_addr_o` change only in the cycle that follows a committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the bank |
| req_i | input | 1 | Host access request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid while ack_o is high |
| ack_o | output | 1 | Access acknowledge |
| status_i | input | 8 | Status byte returned at 0x03 |
| cfg_rdata_i | input | 8 | Readback data returned at 0x04 |
| cfg_wdata_o | output | 8 | Configuration data written to 0x04 |
| cfg_wr_stb_o | output | 1 | One-cycle pulse on a write to 0x04 |
| cfg_rd_stb_o | output | 1 | One-cycle pulse on a read of 0x04 |
| user_rdata_i | input | 8 | User logic read data |
| user_stb_o | output | 1 | One-cycle pulse on a user window access |
| user_we_o | output | 1 | Direction of the user window access |
| user_addr_o | output | 4 | Offset within the user window |
| user_wdata_o | output | 8 | Write data for the user window |
| glob_reset_req_o | output | 1 | Global set/reset request, active high |
| readback_req_n_o | output | 1 | Readback request, active low |
| program_req_n_o | output | 1 | Program request, active low |
| ctrl2_o | output | 8 | Contents of control register 2 |
| rb_addr_o | output | 16 | Readback address |

## Verification
The assertions check the handshake and the output signals on every cycle:
- `ack_o` holds while the request stays high and releases one edge after it falls.
- Strobes are mutually exclusive.
- A user or configuration strobe lasts a single cycle and is followed by an acknowledge.
- The request outputs, `ctrl2_o` and the readback address never move without a committed write.

Only the bench's scenarios can show the byte-level contents:
- the reset values and the read-back values;
- the masking of reserved control bits;
- the device identifier byte order;
- the no-effect writes to read-only and reserved addresses;
- the two-edge acknowledge latency;
- the fact that asserting global set/reset or program leaves every bank register intact.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } acc_state_e;

    // Register offsets within the lower half of the map
    localparam logic [3:0] OFS_CTRL1   = 4'h0;
    localparam logic [3:0] OFS_CTRL2   = 4'h1;
    localparam logic [3:0] OFS_SCRATCH = 4'h2;
    localparam logic [3:0] OFS_STATUS  = 4'h3;
    localparam logic [3:0] OFS_CFGDATA = 4'h4;
    localparam logic [3:0] OFS_RBA_LO  = 4'h5;
    localparam logic [3:0] OFS_RBA_HI  = 4'h6;
    localparam logic [3:0] OFS_ID0     = 4'h7;
    localparam logic [3:0] OFS_ID1     = 4'h8;
    localparam logic [3:0] OFS_ID2     = 4'h9;
    localparam logic [3:0] OFS_ID3     = 4'hA;

    // Control register 1 bit positions
    localparam int BIT_GSR  = 0;
    localparam int BIT_RBK  = 5;
    localparam int BIT_PROG = 7;

endpackage

// File: rtl/hcb_access_fsm.sv
module hcb_access_fsm
    import hcb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              exec_o,
    output logic              ack_o,
    output logic              we_q_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] wdata_q_o
);

    acc_state_e state_q, state_d;

    // State register and request latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            we_q_o    <= 1'b0;
            addr_q_o  <= '0;
            wdata_q_o <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_i) begin
                we_q_o    <= we_i;
                addr_q_o  <= addr_i;
                wdata_q_o <= wdata_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_EXEC;   // IDLE_TO_EXEC
            ST_EXEC: state_d = ST_DONE;              // EXEC_TO_DONE
            ST_DONE: if (!req_i) state_d = ST_IDLE;  // DONE_TO_IDLE, else DONE_HOLD
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        exec_o = 1'b0;
        ack_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EXEC: exec_o = 1'b1;
            ST_DONE: ack_o  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/hcb_strobe_dec.sv
module hcb_strobe_dec
    import hcb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              exec_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wr_en_o,
    output logic              rd_en_o,
    output logic              user_stb_o,
    output logic              cfg_wr_stb_o,
    output logic              cfg_rd_stb_o
);

    localparam int OFS_W = ADDR_W - 1;

    logic in_user;
    logic at_cfg;

    assign in_user = addr_i[ADDR_W-1];
    assign at_cfg  = !in_user && (addr_i[OFS_W-1:0] == OFS_CFGDATA);

    assign wr_en_o      = exec_i && we_i;
    assign rd_en_o      = exec_i && !we_i;
    assign user_stb_o   = exec_i && in_user;
    assign cfg_wr_stb_o = exec_i && we_i && at_cfg;
    assign cfg_rd_stb_o = exec_i && !we_i && at_cfg;

endmodule

// File: rtl/hcb_regs.sv
module hcb_regs
    import hcb_pkg::*;
#(
    parameter int          ADDR_W    = 5,
    parameter int          DATA_W    = 8,
    parameter logic [31:0] DEVICE_ID = 32'h0013_6A2B
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] cfg_rdata_i,
    input  logic [DATA_W-1:0] user_rdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              gsr_o,
    output logic              rbk_n_o,
    output logic              prog_n_o,
    output logic [DATA_W-1:0] ctrl2_o,
    output logic [2*DATA_W-1:0] rb_addr_o
);

    localparam int OFS_W    = ADDR_W - 1;
    localparam int ID_BYTES = 32 / DATA_W;

    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] rba_lo_q, rba_hi_q;
    logic [DATA_W-1:0] ctrl1_view;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] id_byte [ID_BYTES];
    logic [OFS_W-1:0]  ofs;

    assign ofs = addr_i[OFS_W-1:0];

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
        assign id_byte[g] = DEVICE_ID[DATA_W*g +: DATA_W];
    end

    // Bank storage: cleared only by rst_ni, never by the requests it drives
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gsr_o     <= 1'b0;
            rbk_n_o   <= 1'b1;
            prog_n_o  <= 1'b1;
            ctrl2_o   <= '0;
            scratch_q <= '0;
            rba_lo_q  <= '0;
            rba_hi_q  <= '0;
        end else if (wr_en_i && !addr_i[ADDR_W-1]) begin
            case (ofs)
                OFS_CTRL1: begin
                    gsr_o    <= wdata_i[BIT_GSR];
                    rbk_n_o  <= wdata_i[BIT_RBK];
                    prog_n_o <= wdata_i[BIT_PROG];
                end
                OFS_CTRL2:   ctrl2_o   <= wdata_i;
                OFS_SCRATCH: scratch_q <= wdata_i;
                OFS_RBA_LO:  rba_lo_q  <= wdata_i;
                OFS_RBA_HI:  rba_hi_q  <= wdata_i;
                default: ;
            endcase
        end
    end

    assign rb_addr_o = {rba_hi_q, rba_lo_q};

    always_comb begin
        ctrl1_view           = '0;
        ctrl1_view[BIT_GSR]  = gsr_o;
        ctrl1_view[BIT_RBK]  = rbk_n_o;
        ctrl1_view[BIT_PROG] = prog_n_o;
    end

    always_comb begin
        rd_mux = '0;
        if (addr_i[ADDR_W-1]) begin
            rd_mux = user_rdata_i;
        end else begin
            case (ofs)
                OFS_CTRL1:   rd_mux = ctrl1_view;
                OFS_CTRL2:   rd_mux = ctrl2_o;
                OFS_SCRATCH: rd_mux = scratch_q;
                OFS_STATUS:  rd_mux = status_i;
                OFS_CFGDATA: rd_mux = cfg_rdata_i;
                OFS_RBA_LO:  rd_mux = rba_lo_q;
                OFS_RBA_HI:  rd_mux = rba_hi_q;
                OFS_ID0:     rd_mux = id_byte[0];
                OFS_ID1:     rd_mux = id_byte[1];
                OFS_ID2:     rd_mux = id_byte[2];
                OFS_ID3:     rd_mux = id_byte[3];
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/host_ctrl_bank.sv
module host_ctrl_bank #(
    parameter int          ADDR_W    = 5,
    parameter int          DATA_W    = 8,
    parameter logic [31:0] DEVICE_ID = 32'h0013_6A2B
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                ack_o,
    input  logic [DATA_W-1:0]   status_i,
    input  logic [DATA_W-1:0]   cfg_rdata_i,
    output logic [DATA_W-1:0]   cfg_wdata_o,
    output logic                cfg_wr_stb_o,
    output logic                cfg_rd_stb_o,
    input  logic [DATA_W-1:0]   user_rdata_i,
    output logic                user_stb_o,
    output logic                user_we_o,
    output logic [ADDR_W-2:0]   user_addr_o,
    output logic [DATA_W-1:0]   user_wdata_o,
    output logic                glob_reset_req_o,
    output logic                readback_req_n_o,
    output logic                program_req_n_o,
    output logic [DATA_W-1:0]   ctrl2_o,
    output logic [2*DATA_W-1:0] rb_addr_o
);

    logic              exec_w;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_en_w;
    logic              rd_en_w;

    hcb_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .exec_o    (exec_w),
        .ack_o     (ack_o),
        .we_q_o    (we_q),
        .addr_q_o  (addr_q),
        .wdata_q_o (wdata_q)
    );

    hcb_strobe_dec #(.ADDR_W(ADDR_W)) u_dec (
        .exec_i       (exec_w),
        .we_i         (we_q),
        .addr_i       (addr_q),
        .wr_en_o      (wr_en_w),
        .rd_en_o      (rd_en_w),
        .user_stb_o   (user_stb_o),
        .cfg_wr_stb_o (cfg_wr_stb_o),
        .cfg_rd_stb_o (cfg_rd_stb_o)
    );

    hcb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEVICE_ID(DEVICE_ID)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_w),
        .rd_en_i      (rd_en_w),
        .addr_i       (addr_q),
        .wdata_i      (wdata_q),
        .status_i     (status_i),
        .cfg_rdata_i  (cfg_rdata_i),
        .user_rdata_i (user_rdata_i),
        .rdata_o      (rdata_o),
        .gsr_o        (glob_reset_req_o),
        .rbk_n_o      (readback_req_n_o),
        .prog_n_o     (program_req_n_o),
        .ctrl2_o      (ctrl2_o),
        .rb_addr_o    (rb_addr_o)
    );

    assign cfg_wdata_o  = wdata_q;
    assign user_we_o    = we_q;
    assign user_addr_o  = addr_q[ADDR_W-2:0];
    assign user_wdata_o = wdata_q;

endmodule

// File: rtl/host_ctrl_bank_chk.sv
module host_ctrl_bank_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_i,
    input logic                ack_o,
    input logic                wr_en,
    input logic                user_stb_o,
    input logic                cfg_wr_stb_o,
    input logic                cfg_rd_stb_o,
    input logic                glob_reset_req_o,
    input logic                readback_req_n_o,
    input logic                program_req_n_o,
    input logic [DATA_W-1:0]   ctrl2_o,
    input logic [2*DATA_W-1:0] rb_addr_o
);

    assert_ack_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && req_i) |=> ack_o);

    assert_ack_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && !req_i) |=> !ack_o);

    assert_req_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en |=> $stable({glob_reset_req_o, readback_req_n_o, program_req_n_o}));

    assert_bank_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en |=> ($stable(rb_addr_o) && $stable(ctrl2_o)));

    assert_cfg_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_stb_o || cfg_rd_stb_o) |=> (!cfg_wr_stb_o && !cfg_rd_stb_o && ack_o));

    assert_user_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        user_stb_o |=> (!user_stb_o && ack_o));

    assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({user_stb_o, cfg_wr_stb_o, cfg_rd_stb_o}));

endmodule

bind host_ctrl_bank host_ctrl_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_i            (req_i),
    .ack_o            (ack_o),
    .wr_en            (wr_en_w),
    .user_stb_o       (user_stb_o),
    .cfg_wr_stb_o     (cfg_wr_stb_o),
    .cfg_rd_stb_o     (cfg_rd_stb_o),
    .glob_reset_req_o (glob_reset_req_o),
    .readback_req_n_o (readback_req_n_o),
    .program_req_n_o  (program_req_n_o),
    .ctrl2_o          (ctrl2_o),
    .rb_addr_o        (rb_addr_o)
);

// File: tb/host_ctrl_bank_tb.sv
module host_ctrl_bank_tb;

    localparam logic [31:0] TB_ID     = 32'h5A3C_0F81;
    localparam logic [7:0]  TB_STATUS = 8'h3B;
    localparam logic [7:0]  TB_CFGRD  = 8'hC7;
    localparam logic [7:0]  TB_USERRD = 8'h5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ack;
    logic [7:0]  cfg_wdata, ctrl2;
    logic        cfg_wr_stb, cfg_rd_stb;
    logic        user_stb, user_we;
    logic [3:0]  user_addr;
    logic [7:0]  user_wdata;
    logic        gsr, rbk_n, prog_n;
    logic [15:0] rb_addr;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;  // 250 MHz

    host_ctrl_bank #(.DEVICE_ID(TB_ID)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .status_i(TB_STATUS),
        .cfg_rdata_i(TB_CFGRD), .cfg_wdata_o(cfg_wdata), .cfg_wr_stb_o(cfg_wr_stb),
        .cfg_rd_stb_o(cfg_rd_stb), .user_rdata_i(TB_USERRD), .user_stb_o(user_stb),
        .user_we_o(user_we), .user_addr_o(user_addr), .user_wdata_o(user_wdata),
        .glob_reset_req_o(gsr), .readback_req_n_o(rbk_n), .program_req_n_o(prog_n),
        .ctrl2_o(ctrl2), .rb_addr_o(rb_addr)
    );

    // Strobe monitors, sampled away from the active edge
    int       n_user = 0, n_cfgw = 0, n_cfgr = 0;
    logic [3:0] cap_uaddr;
    logic [7:0] cap_uwdata, cap_cfgw;
    logic       cap_uwe;
    always @(negedge clk) begin
        if (user_stb)   begin n_user++; cap_uaddr = user_addr; cap_uwdata = user_wdata; cap_uwe = user_we; end
        if (cfg_wr_stb) begin n_cfgw++; cap_cfgw = cfg_wdata; end
        if (cfg_rd_stb) n_cfgr++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [4:0] a, input logic [7:0] d,
                          output logic [7:0] r, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
        do begin @(negedge clk); lat++; end while (!ack && lat < 20);
        r = rdata;
        req = 1'b0;
        @(negedge clk);
    endtask

    // {we, addr, wdata, expected read, requirement number}
    localparam int NV = 26;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 5'h00, 8'h00, 8'hA0, 4'd1},  // R1 default control
        {1'b1, 5'h02, 8'h55, 8'h00, 4'd5},
        {1'b0, 5'h02, 8'h00, 8'h55, 4'd5},  // R5 scratchpad
        {1'b1, 5'h01, 8'h3C, 8'h00, 4'd5},
        {1'b0, 5'h01, 8'h00, 8'h3C, 4'd5},  // R5 control 2
        {1'b1, 5'h05, 8'h34, 8'h00, 4'd5},
        {1'b1, 5'h06, 8'h12, 8'h00, 4'd5},
        {1'b0, 5'h05, 8'h00, 8'h34, 4'd5},
        {1'b0, 5'h06, 8'h00, 8'h12, 4'd5},
        {1'b0, 5'h03, 8'h00, 8'h3B, 4'd6},  // R6 status
        {1'b1, 5'h03, 8'hFF, 8'h00, 4'd6},
        {1'b0, 5'h03, 8'h00, 8'h3B, 4'd6},
        {1'b0, 5'h07, 8'h00, 8'h81, 4'd8},  // R8 ID byte order
        {1'b0, 5'h08, 8'h00, 8'h0F, 4'd8},
        {1'b0, 5'h09, 8'h00, 8'h3C, 4'd8},
        {1'b0, 5'h0A, 8'h00, 8'h5A, 4'd8},
        {1'b1, 5'h08, 8'h00, 8'h00, 4'd8},
        {1'b0, 5'h08, 8'h00, 8'h0F, 4'd8},
        {1'b1, 5'h0B, 8'hAA, 8'h00, 4'd9},  // R9 reserved
        {1'b0, 5'h0B, 8'h00, 8'h00, 4'd9},
        {1'b0, 5'h0F, 8'h00, 8'h00, 4'd9},
        {1'b1, 5'h00, 8'hFF, 8'h00, 4'd4},
        {1'b0, 5'h00, 8'h00, 8'hA1, 4'd4},  // R4 reserved bits masked
        {1'b1, 5'h00, 8'hA0, 8'h00, 4'd3},
        {1'b0, 5'h04, 8'h00, 8'hC7, 4'd7},  // R7 config read
        {1'b0, 5'h1F, 8'h00, 8'h5C, 4'd10}  // R10 user read
    };

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int lat;
        int u0, c0;

        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1 gsr", gsr, 0);
        check("R1 readback_n", rbk_n, 1);
        check("R1 program_n", prog_n, 1);
        check("R1 ack", ack, 0);
        check("R1 rb_addr", rb_addr, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][25], VEC[i][24:20], VEC[i][19:12], r, lat);
            if (!VEC[i][25]) begin
                tests++;
                if (r !== VEC[i][11:4]) begin
                    fails++;
                    $display("FAIL R%0d vec %0d addr %0h actual=%0h expected=%0h",
                             VEC[i][3:0], i, VEC[i][24:20], r, VEC[i][11:4]);
                end
            end
        end

        // R2 latency and release
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 5'h02; lat = 0;
        do begin @(negedge clk); lat++; end while (!ack && lat < 20);
        check("R2 ack latency", lat, 2);
        repeat (3) @(negedge clk);
        check("R2 ack held", ack, 1);
        check("R2 rdata held", rdata, 8'h55);
        req = 1'b0;
        @(negedge clk);
        check("R2 ack released", ack, 0);

        // R5 outputs mirror registers
        check("R5 rb_addr_o", rb_addr, 16'h1234);
        check("R5 ctrl2_o", ctrl2, 8'h3C);

        // R3 request bits
        access(1'b1, 5'h00, 8'h21, r, lat);
        check("R3 gsr set", gsr, 1);
        check("R3 program_n low", prog_n, 0);
        check("R3 readback_n high", rbk_n, 1);
        repeat (5) @(negedge clk);
        check("R3 gsr holds", gsr, 1);

        // R11 bank survives gsr and program requests
        access(1'b0, 5'h02, 8'h00, r, lat);
        check("R11 scratch kept", r, 8'h55);
        access(1'b0, 5'h01, 8'h00, r, lat);
        check("R11 ctrl2 kept", r, 8'h3C);
        check("R11 rb_addr kept", rb_addr, 16'h1234);
        access(1'b1, 5'h02, 8'hE4, r, lat);
        access(1'b0, 5'h02, 8'h00, r, lat);
        check("R11 scratch writable", r, 8'hE4);
        access(1'b0, 5'h00, 8'h00, r, lat);
        check("R11 ctrl1 kept", r, 8'h21);

        access(1'b1, 5'h00, 8'h80, r, lat);
        check("R3 gsr cleared", gsr, 0);
        check("R3 readback_n low", rbk_n, 0);
        check("R3 program_n high", prog_n, 1);

        // R10 user window write and R12 exclusivity
        u0 = n_user; c0 = n_cfgw + n_cfgr;
        access(1'b1, 5'h13, 8'h9E, r, lat);
        check("R10 user strobe count", n_user - u0, 1);
        check("R10 user addr", cap_uaddr, 4'h3);
        check("R10 user wdata", cap_uwdata, 8'h9E);
        check("R10 user we", cap_uwe, 1);
        check("R12 no cfg strobe on user", n_cfgw + n_cfgr - c0, 0);
        access(1'b0, 5'h1A, 8'h00, r, lat);
        check("R10 user read we", cap_uwe, 0);
        check("R10 user read addr", cap_uaddr, 4'hA);

        // R7 config write strobe
        u0 = n_user; c0 = n_cfgw;
        access(1'b1, 5'h04, 8'h6D, r, lat);
        check("R7 cfg wr count", n_cfgw - c0, 1);
        check("R7 cfg wdata", cap_cfgw, 8'h6D);
        check("R12 no user strobe on cfg", n_user - u0, 0);
        c0 = n_cfgr;
        access(1'b0, 5'h04, 8'h00, r, lat);
        check("R7 cfg rd count", n_cfgr - c0, 1);
        check("R7 cfg read data", r, TB_CFGRD);

        // R9 reserved write did not disturb neighbours
        access(1'b1, 5'h0E, 8'hFF, r, lat);
        access(1'b0, 5'h06, 8'h00, r, lat);
        check("R9 rba hi intact", r, 8'h12);

        // R1 reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rbk_n after reset", rbk_n, 1);
        access(1'b0, 5'h00, 8'h00, r, lat);
        check("R1 ctrl1 after reset", r, 8'hA0);
        access(1'b0, 5'h02, 8'h00, r, lat);
        check("R1 scratch after reset", r, 8'h00);
        check("R1 rb_addr after reset", rb_addr, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule